// File: doc/BRIEF.md
# Overcurrent and Idle-Load Fault Timer

This block watches the output current of a powered port and decides when that current has been too high for too long, or too low for too long. The current is sampled once per millisecond tick. A trip threshold is picked from the class granted to the attached device. While the sample is above that threshold, an integrating counter rises by one per tick. While the sample is at or below it, the counter drains sixteen times more slowly. Brief overloads that repeat therefore add up and can still reach the trip point, even when each one on its own is too short to trip.

A second, independent counter measures how long the current has stayed under a small idle level. When that time runs too long, it reports that the device has gone away. Each of the two detectors gives a one-cycle pulse and a flag that stays set. Both detectors freeze once they have fired. They are wiped when the port is unpowered (enable low) or when the synchronous clear is asserted. Current measurement and the port shutdown sequence are handled outside this block.

Top module: `oc_fault_timer`

## Requirements
- R1: The 2-bit `class_sel` input selects the trip threshold in units of 0.5 mA: code 0 selects `LIM_C0` (default 800 = 400 mA), code 1 selects `LIM_C1` (196 = 98 mA), code 2 selects `LIM_C2` (360 = 180 mA) and code 3 (class 3/4) selects `LIM_C34` (800 = 400 mA).
- R2: On a tick where `cur_sample` is strictly greater than the selected threshold, the overcurrent count rises by one and the decay prescaler restarts from zero.
- R3: When a tick brings the overcurrent count to `TRIP_MS`, `oc_pulse` is high for exactly the one cycle after that clock edge, and `oc_fault` is set at the same edge.
- R4: On a tick where the sample does not exceed the threshold and the count is nonzero, the prescaler advances. The count falls by one on every 2^`DECAY_LOG2`-th such consecutive tick (16 by default). At a count of zero, the prescaler is held at zero and the count does not go below zero.
- R5: Once `oc_fault` is set, it stays set and the overcurrent count stays frozen until enable goes low or clear is asserted.
- R6: A clock edge with `enable` low or `clear` high returns both counters, the prescaler, both flags and both pulses to zero. Clear takes priority over every other input.
- R7: A tick with `cur_sample` below `IDLE_LIM` (default 15 = 7.5 mA) counts as idle. On the idle tick that follows `DISC_MS` consecutive idle ticks (that is, idle for more than `DISC_MS` ms), `disc_pulse` is high for one cycle and `disc_fault` is set. `disc_fault` stays set until enable goes low or clear is asserted.
- R8: A tick with `cur_sample` at or above `IDLE_LIM` restarts the idle count from zero.
- R9: Without `tick_ms`, neither counter changes and no pulse is produced.
- R10: After reset, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | High while the port is powered |
| clear | input | 1 | Synchronous clear of all state |
| tick_ms | input | 1 | One-cycle 1 ms time base strobe |
| class_sel | input | 2 | Granted class code (0, 1, 2, 3 = class 3/4) |
| cur_sample | input | CUR_W | Output current sample, 0.5 mA per LSB |
| oc_pulse | output | 1 | One-cycle overcurrent trip pulse |
| oc_fault | output | 1 | Sticky overcurrent flag |
| disc_pulse | output | 1 | One-cycle disconnect pulse |
| disc_fault | output | 1 | Sticky disconnect flag |

## Verification
The bench builds the block with `TRIP_MS` = 12, `DECAY_LOG2` = 2 and `DISC_MS` = 20, and keeps the default thresholds. With a trip after 12 ticks, a decay step every 4 ticks and a disconnect after 21 idle ticks, random runs of a few thousand steps reach repeated trips, decays that saturate at zero, and disconnects. A bench reference model is compared against every output at every step. Directed cases cover the boundary where the sample equals the threshold for every class, a sample exactly at the idle level, clear during a trip, and long runs of cycles with no tick.

// File: rtl/oct_pkg.sv
package oct_pkg;

  typedef enum logic [1:0] {
    CLS_0  = 2'd0,
    CLS_1  = 2'd1,
    CLS_2  = 2'd2,
    CLS_34 = 2'd3
  } pwr_class_e;

endpackage

// File: rtl/oct_limit_sel.sv
module oct_limit_sel
  import oct_pkg::*;
#(
  parameter int CUR_W   = 12,
  parameter int LIM_C0  = 800,
  parameter int LIM_C1  = 196,
  parameter int LIM_C2  = 360,
  parameter int LIM_C34 = 800
) (
  input  pwr_class_e       cls,
  input  logic [CUR_W-1:0] sample,
  output logic             over
);

  logic [CUR_W-1:0] limit;

  always_comb begin
    case (cls)
      CLS_1:   limit = CUR_W'(LIM_C1);
      CLS_2:   limit = CUR_W'(LIM_C2);
      CLS_34:  limit = CUR_W'(LIM_C34);
      default: limit = CUR_W'(LIM_C0);
    endcase
  end

  assign over = (sample > limit);

endmodule

// File: rtl/oct_trip_timer.sv
module oct_trip_timer #(
  parameter int TRIP_MS    = 60,
  parameter int DECAY_LOG2 = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic flush,
  input  logic tick,
  input  logic over,
  output logic fault_pulse,
  output logic fault_flag
);

  localparam int CW = $clog2(TRIP_MS + 1);
  localparam int PW = DECAY_LOG2;
  localparam logic [CW-1:0] TRIP_V = CW'(TRIP_MS);
  localparam logic [CW-1:0] LAST_V = CW'(TRIP_MS - 1);
  localparam logic [PW-1:0] PRE_MAX = {PW{1'b1}};

  logic [CW-1:0] cnt_q, cnt_d;
  logic [PW-1:0] pre_q, pre_d;
  logic          flag_q, flag_d;
  logic          pulse_q, pulse_d;
  logic          step_en;

  assign step_en = tick && !flag_q;

  always_comb begin
    cnt_d   = cnt_q;
    pre_d   = pre_q;
    flag_d  = flag_q;
    pulse_d = 1'b0;
    if (flush) begin
      cnt_d  = '0;
      pre_d  = '0;
      flag_d = 1'b0;
    end else if (step_en) begin
      if (over) begin
        pre_d = '0;
        if (cnt_q == LAST_V) begin
          cnt_d   = TRIP_V;
          flag_d  = 1'b1;
          pulse_d = 1'b1;
        end else begin
          cnt_d = cnt_q + CW'(1);
        end
      end else if (cnt_q != '0) begin
        if (pre_q == PRE_MAX) begin
          pre_d = '0;
          cnt_d = cnt_q - CW'(1);
        end else begin
          pre_d = pre_q + PW'(1);
        end
      end else begin
        pre_d = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      pre_q   <= '0;
      flag_q  <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      pre_q   <= pre_d;
      flag_q  <= flag_d;
      pulse_q <= pulse_d;
    end
  end

  assign fault_pulse = pulse_q;
  assign fault_flag  = flag_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= TRIP_V); // R3
  AST_UP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && over && !flush && !flag_q) |=> (cnt_q == $past(cnt_q) + CW'(1))); // R2
  AST_DECAY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !over && !flush && !flag_q && pre_q != PRE_MAX) |=> $stable(cnt_q)); // R4
  AST_PULSE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    fault_pulse |=> !fault_pulse); // R3
  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !flush) |=> (flag_q && $stable(cnt_q))); // R5
  AST_FLUSH_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (!flag_q && !pulse_q && cnt_q == '0)); // R6
  AST_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !flush) |=> ($stable(cnt_q) && !pulse_q)); // R9

endmodule

// File: rtl/oct_idle_timer.sv
module oct_idle_timer #(
  parameter int DISC_MS = 350
) (
  input  logic clk,
  input  logic rst_n,
  input  logic flush,
  input  logic tick,
  input  logic idle,
  output logic disc_pulse,
  output logic disc_flag
);

  localparam int DW = $clog2(DISC_MS + 2);
  localparam logic [DW-1:0] DISC_V = DW'(DISC_MS);

  logic [DW-1:0] dcnt_q, dcnt_d;
  logic          flag_q, flag_d;
  logic          pulse_q, pulse_d;

  always_comb begin
    dcnt_d  = dcnt_q;
    flag_d  = flag_q;
    pulse_d = 1'b0;
    if (flush) begin
      dcnt_d = '0;
      flag_d = 1'b0;
    end else if (tick && !flag_q) begin
      if (!idle) begin
        dcnt_d = '0;
      end else if (dcnt_q == DISC_V) begin
        dcnt_d  = dcnt_q + DW'(1);
        flag_d  = 1'b1;
        pulse_d = 1'b1;
      end else begin
        dcnt_d = dcnt_q + DW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dcnt_q  <= '0;
      flag_q  <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      dcnt_q  <= dcnt_d;
      flag_q  <= flag_d;
      pulse_q <= pulse_d;
    end
  end

  assign disc_pulse = pulse_q;
  assign disc_flag  = flag_q;

  AST_IDLE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !idle && !flush && !flag_q) |=> (dcnt_q == '0)); // R8
  AST_DISC_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    disc_pulse |=> !disc_pulse); // R7
  AST_DISC_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !flush) |=> flag_q); // R7
  AST_DISC_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (!flag_q && dcnt_q == '0)); // R6

endmodule

// File: rtl/oc_fault_timer.sv
module oc_fault_timer
  import oct_pkg::*;
#(
  parameter int CUR_W      = 12,
  parameter int LIM_C0     = 800,
  parameter int LIM_C1     = 196,
  parameter int LIM_C2     = 360,
  parameter int LIM_C34    = 800,
  parameter int IDLE_LIM   = 15,
  parameter int TRIP_MS    = 60,
  parameter int DECAY_LOG2 = 4,
  parameter int DISC_MS    = 350
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             clear,
  input  logic             tick_ms,
  input  logic [1:0]       class_sel,
  input  logic [CUR_W-1:0] cur_sample,
  output logic             oc_pulse,
  output logic             oc_fault,
  output logic             disc_pulse,
  output logic             disc_fault
);

  logic flush;
  logic over;
  logic idle;

  assign flush = clear || !enable;
  assign idle  = (cur_sample < CUR_W'(IDLE_LIM));

  oct_limit_sel #(
    .CUR_W  (CUR_W),
    .LIM_C0 (LIM_C0),
    .LIM_C1 (LIM_C1),
    .LIM_C2 (LIM_C2),
    .LIM_C34(LIM_C34)
  ) u_lim (
    .cls   (pwr_class_e'(class_sel)),
    .sample(cur_sample),
    .over  (over)
  );

  oct_trip_timer #(
    .TRIP_MS   (TRIP_MS),
    .DECAY_LOG2(DECAY_LOG2)
  ) u_trip (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush      (flush),
    .tick       (tick_ms),
    .over       (over),
    .fault_pulse(oc_pulse),
    .fault_flag (oc_fault)
  );

  oct_idle_timer #(
    .DISC_MS(DISC_MS)
  ) u_idle (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush),
    .tick      (tick_ms),
    .idle      (idle),
    .disc_pulse(disc_pulse),
    .disc_flag (disc_fault)
  );

  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!oc_fault && !disc_fault && !oc_pulse && !disc_pulse)); // R6
  AST_PULSE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    oc_pulse |-> oc_fault); // R3

endmodule

// File: tb/oc_fault_timer_test.sv
module oc_fault_timer_test;

  localparam int CUR_W = 12;
  localparam int TRIP  = 12;
  localparam int DLOG  = 2;
  localparam int DIV   = 1 << DLOG;
  localparam int DISC  = 20;
  localparam int IDLE  = 15;

  logic clk = 1'b0;
  logic rst_n;
  logic enable, clear, tick_ms;
  logic [1:0] class_sel;
  logic [CUR_W-1:0] cur_sample;
  logic oc_pulse, oc_fault, disc_pulse, disc_fault;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  int m_cnt, m_pre, m_dc;
  bit m_flag, m_pulse, m_dflag, m_dpulse;

  always #5 clk = ~clk;

  oc_fault_timer #(
    .CUR_W(CUR_W), .IDLE_LIM(IDLE), .TRIP_MS(TRIP),
    .DECAY_LOG2(DLOG), .DISC_MS(DISC)
  ) uut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .clear(clear),
    .tick_ms(tick_ms), .class_sel(class_sel), .cur_sample(cur_sample),
    .oc_pulse(oc_pulse), .oc_fault(oc_fault),
    .disc_pulse(disc_pulse), .disc_fault(disc_fault)
  );

  function automatic int limit_of(int cls);
    case (cls)
      1: return 196;
      2: return 360;
      default: return 800;
    endcase
  endfunction

  task automatic check(string tag, string what, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic model(bit en, bit clr, bit tk, int cls, int smp);
    m_pulse  = 0;
    m_dpulse = 0;
    if (clr || !en) begin
      m_cnt = 0; m_pre = 0; m_flag = 0; m_dc = 0; m_dflag = 0;
    end else if (tk) begin
      if (!m_flag) begin
        if (smp > limit_of(cls)) begin
          m_pre = 0;
          if (m_cnt == TRIP - 1) begin
            m_cnt = TRIP; m_flag = 1; m_pulse = 1;
          end else m_cnt++;
        end else if (m_cnt > 0) begin
          if (m_pre == DIV - 1) begin m_pre = 0; m_cnt--; end
          else m_pre++;
        end else m_pre = 0;
      end
      if (!m_dflag) begin
        if (smp >= IDLE) m_dc = 0;
        else if (m_dc == DISC) begin m_dc++; m_dflag = 1; m_dpulse = 1; end
        else m_dc++;
      end
    end
  endtask

  task automatic step(string tag, bit en, bit clr, bit tk, int cls, int smp);
    @(negedge clk);
    enable = en; clear = clr; tick_ms = tk;
    class_sel = 2'(cls); cur_sample = CUR_W'(smp);
    @(posedge clk);
    model(en, clr, tk, cls, smp);
    #2;
    check(tag, "oc_pulse",   oc_pulse,   m_pulse);
    check(tag, "oc_fault",   oc_fault,   m_flag);
    check(tag, "disc_pulse", disc_pulse, m_dpulse);
    check(tag, "disc_fault", disc_fault, m_dflag);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; enable = 0; clear = 0; tick_ms = 0; class_sel = 0; cur_sample = '0;
    m_cnt = 0; m_pre = 0; m_dc = 0;
    m_flag = 0; m_pulse = 0; m_dflag = 0; m_dpulse = 0;
    void'($urandom(32'd7321));
    repeat (3) @(posedge clk);
    #2;
    check("R10", "oc_fault", oc_fault, 1'b0);
    check("R10", "oc_pulse", oc_pulse, 1'b0);
    check("R10", "disc_fault", disc_fault, 1'b0);
    check("R10", "disc_pulse", disc_pulse, 1'b0);
    @(negedge clk) rst_n = 1;

    // R1: equal to the limit never trips, one above does, per class
    for (int c = 0; c < 4; c++) begin
      step("R6", 1, 1, 0, c, 0);
      for (int k = 0; k < TRIP + 3; k++) step("R1", 1, 0, 1, c, limit_of(c));
      for (int k = 0; k < TRIP + 1; k++) step("R1", 1, 0, 1, c, limit_of(c) + 1);
    end

    // R5: frozen while flagged, then R6 clear priority
    for (int k = 0; k < 10; k++) step("R5", 1, 0, 1, 2, 4000);
    step("R6", 1, 1, 1, 2, 4000);

    // R4: build up, decay partially, to zero, and floor
    for (int k = 0; k < 5; k++) step("R2", 1, 0, 1, 1, 300);
    for (int k = 0; k < 3 * DIV + 1; k++) step("R4", 1, 0, 1, 1, 100);
    for (int k = 0; k < TRIP; k++) step("R4", 1, 0, 1, 1, 300);
    step("R6", 0, 0, 1, 1, 0);
    for (int k = 0; k < 3; k++) step("R2", 1, 0, 1, 1, 300);
    for (int k = 0; k < 6 * DIV; k++) step("R4", 1, 0, 1, 1, 50);
    for (int k = 0; k < TRIP; k++) step("R4", 1, 0, 1, 1, 300);

    // R9: no tick means nothing moves
    step("R6", 1, 1, 0, 0, 0);
    for (int k = 0; k < 60; k++) step("R9", 1, 0, 0, 0, 2000);
    for (int k = 0; k < 60; k++) step("R9", 1, 0, 0, 0, 0);

    // R7 / R8: idle run broken at exactly the idle level, then full run
    for (int k = 0; k < DISC; k++) step("R7", 1, 0, 1, 0, IDLE - 1);
    step("R8", 1, 0, 1, 0, IDLE);
    for (int k = 0; k < DISC + 3; k++) step("R7", 1, 0, 1, 0, 0);
    step("R6", 0, 0, 0, 0, 0);

    // random mix
    for (int ph = 0; ph < 3; ph++) begin
      for (int n = 0; n < 1500; n++) begin
        int c, s, r, pov;
        bit en, cl, tk;
        c  = int'($urandom_range(0, 3));
        pov = (ph == 0) ? 40 : (ph == 1) ? 70 : 20;
        r  = int'($urandom_range(0, 99));
        if (r < pov) s = limit_of(c) + 1 + int'($urandom_range(0, 200));
        else if (r < pov + 15) s = int'($urandom_range(0, IDLE - 1));
        else s = int'($urandom_range(IDLE - 1, limit_of(c)));
        tk = ($urandom_range(0, 9) < 7);
        en = ($urandom_range(0, 299) != 0);
        cl = ($urandom_range(0, 399) == 0);
        step("R2 R3 R4 R7", en, cl, tk, c, s);
      end
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule